// File: doc/BRIEF.md
# JTAG Configuration Register Bridge

This block sits behind one test data register of a JTAG port and turns a serial DR scan into accesses on an internal 32-bit configuration register bus. It runs on TCK. Its inputs are the one-hot state indications of an external TAP controller and TDI. Its outputs are TDO with its pad enable, a single-master register bus, and a sticky error report.

Each DR scan opens with one command bit: 0 requests a write and 1 requests a read. A register address follows, least significant bit first. In a write scan the remaining bits are gathered into 32-bit words. Each complete word is written to the address, and each further word goes to the next address. In a read scan the bus request goes out as soon as the address is complete. The tester then parks the TAP in Pause-DR while the bus answers. On the way back into Shift-DR the answer is loaded and shifted out on TDO, LSB first.

A write that stops partway through a word sets an error, and the partial word is dropped. So does a scan that ends during the address, and so does a read whose data has not arrived by the end of the pause. The error stays until a clear pulse or Test-Logic-Reset.

Top module: `jtag_cfg_bridge`

## Requirements
- R1: The first bit shifted after Capture-DR is the command: 0 makes the scan a write, 1 makes it a read.
- R2: The next AW bits form the register address, LSB first. It is held for the rest of the scan and presented on `bus_addr` for the access.
- R3: In a write scan, data bits follow the address, LSB first. Each complete DW-bit word produces exactly one single-cycle `bus_wr` pulse, in the cycle after its last bit, carrying that word and the held address.
- R4: Each further complete word in the same write scan goes to the previous word's address plus one, wrapping modulo 2^AW.
- R5: During every Shift-DR cycle of a write scan, TDO is 0.
- R6: `tdo_oe` is 1 in Shift-DR and 0 in every other TAP state, including the Exit1, Pause and Exit2 states.
- R7: In a read scan, a single-cycle `bus_rd` pulse carrying the address follows the cycle of the last address bit. TDI after the address has no effect: no write is issued.
- R8: Read data returned with `bus_ready` before or during the Exit2-DR cycle is loaded then and appears on TDO, LSB first, over the next DW Shift-DR cycles.
- R9: If a write scan reaches Update-DR with a word only partly filled, the error code becomes 01 and that partial word is not written.
- R10: If a scan reaches Update-DR before the address is complete, the error code becomes 10.
- R11: If read data has not returned by the Exit2-DR cycle, TDO shifts all zeros and the error code becomes 11.
- R12: `err_flag` is set together with a nonzero code. Code 00 means no error. The first code is kept until `err_clr` or `tlr` clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | TCK |
| rst | input | 1 | Synchronous active-high reset |
| tlr | input | 1 | TAP is in Test-Logic-Reset |
| st_capture | input | 1 | TAP is in Capture-DR |
| st_shift | input | 1 | TAP is in Shift-DR |
| st_exit1 | input | 1 | TAP is in Exit1-DR |
| st_pause | input | 1 | TAP is in Pause-DR |
| st_exit2 | input | 1 | TAP is in Exit2-DR |
| st_update | input | 1 | TAP is in Update-DR |
| tdi | input | 1 | Serial data in |
| err_clr | input | 1 | Synchronous clear of the error report |
| tdo | output | 1 | Serial data out |
| tdo_oe | output | 1 | Pad enable for TDO |
| bus_addr | output | AW | Register bus address |
| bus_wdata | output | DW | Register bus write data |
| bus_wr | output | 1 | Write strobe, one cycle |
| bus_rd | output | 1 | Read request, one cycle |
| bus_rdata | input | DW | Read data, valid with bus_ready |
| bus_ready | input | 1 | Read data valid |
| err_flag | output | 1 | Sticky error present |
| err_code | output | 2 | Error cause: 01 partial, 10 aborted, 11 read timeout |

## Verification
Nearly every fault in the scan bookkeeping shows at the ports within one scan. A shift or word counter that is off by one moves the written data or the address by a bit, and the `bus_wr` pulse in the cycle after the last word bit shows it. A phase decode that slips either drives data onto TDO during a write or leaves read data as zeros on the first shift after the pause. A fault in the read capture path, including the case where ready arrives during Exit2-DR, corrupts the 32 TDO bits of that scan. The error code is visible one cycle after Update-DR. For a timeout it is visible two cycles after Exit2-DR.

// File: rtl/jcb_pkg.sv
package jcb_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CMD,
    PH_ADDR,
    PH_WDATA,
    PH_RWAIT,
    PH_RDATA
  } jcb_phase_e;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'b00,
    ERR_PARTIAL = 2'b01,
    ERR_ABORT   = 2'b10,
    ERR_TIMEOUT = 2'b11
  } jcb_err_e;
endpackage

// File: rtl/jcb_wr_path.sv
module jcb_wr_path #(
  parameter int AW = 22,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] base,
  input  logic          bit_en,
  input  logic          tdi,
  output logic          bus_wr,
  output logic [AW-1:0] bus_waddr,
  output logic [DW-1:0] bus_wdata,
  output logic          partial
);
  localparam int CW = $clog2(DW);

  logic [DW-1:0] sh;
  logic [CW-1:0] cnt;
  logic [AW-1:0] nxt_addr;
  logic [DW-1:0] word_next;

  assign word_next = {tdi, sh[DW-1:1]};
  assign partial   = (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh        <= '0;
      cnt       <= '0;
      nxt_addr  <= '0;
      bus_wr    <= 1'b0;
      bus_waddr <= '0;
      bus_wdata <= '0;
    end else begin
      bus_wr <= 1'b0;
      if (start) begin
        cnt      <= '0;
        nxt_addr <= base;
      end else if (bit_en) begin
        sh <= word_next;
        if (cnt == CW'(DW - 1)) begin
          cnt       <= '0;
          bus_wr    <= 1'b1;
          bus_wdata <= word_next;
          bus_waddr <= nxt_addr;
          nxt_addr  <= nxt_addr + 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  p_wr_single_r3: assert property (@(posedge clk) disable iff (rst)
    bus_wr |=> !bus_wr);
  p_wr_after_bit_r3: assert property (@(posedge clk) disable iff (rst)
    bus_wr |-> $past(bit_en));
  p_wr_step_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !start && !bit_en) |=> !bus_wr);
endmodule

// File: rtl/jcb_rd_path.sv
module jcb_rd_path #(
  parameter int AW = 22,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cancel,
  input  logic          req,
  input  logic [AW-1:0] addr_in,
  input  logic          load,
  input  logic          shift_en,
  input  logic          bus_ready,
  input  logic [DW-1:0] bus_rdata,
  output logic          bus_rd,
  output logic [AW-1:0] bus_raddr,
  output logic          tdo_bit,
  output logic          timeout
);
  logic          pend;
  logic          valid;
  logic [DW-1:0] hold;
  logic [DW-1:0] sh;

  assign tdo_bit = sh[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= 1'b0;
      valid     <= 1'b0;
      hold      <= '0;
      sh        <= '0;
      bus_rd    <= 1'b0;
      bus_raddr <= '0;
      timeout   <= 1'b0;
    end else begin
      bus_rd  <= req;
      timeout <= 1'b0;
      if (cancel) begin
        pend  <= 1'b0;
        valid <= 1'b0;
        sh    <= '0;
      end else begin
        if (req) begin
          bus_raddr <= addr_in;
          pend      <= 1'b1;
          valid     <= 1'b0;
        end else if (pend && bus_ready) begin
          hold  <= bus_rdata;
          valid <= 1'b1;
          pend  <= 1'b0;
        end
        if (load) begin
          if (valid) begin
            sh <= hold;
          end else if (pend && bus_ready) begin
            sh <= bus_rdata;
          end else begin
            sh      <= '0;
            timeout <= 1'b1;
          end
          valid <= 1'b0;
          pend  <= 1'b0;
        end else if (shift_en) begin
          sh <= {1'b0, sh[DW-1:1]};
        end
      end
    end
  end

  p_rd_single_r7: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> !bus_rd);
  p_timeout_zero_r11: assert property (@(posedge clk) disable iff (rst)
    timeout |-> !tdo_bit);
endmodule

// File: rtl/jcb_err_sticky.sv
module jcb_err_sticky
  import jcb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       ev_partial,
  input  logic       ev_abort,
  input  logic       ev_timeout,
  output logic       err_flag,
  output logic [1:0] err_code
);
  jcb_err_e code_q;

  assign err_code = code_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      err_flag <= 1'b0;
      code_q   <= ERR_NONE;
    end else if (!err_flag) begin
      if (ev_partial) begin
        err_flag <= 1'b1;
        code_q   <= ERR_PARTIAL;
      end else if (ev_abort) begin
        err_flag <= 1'b1;
        code_q   <= ERR_ABORT;
      end else if (ev_timeout) begin
        err_flag <= 1'b1;
        code_q   <= ERR_TIMEOUT;
      end
    end
  end

  p_sticky_r12: assert property (@(posedge clk) disable iff (rst)
    (err_flag && !clr) |=> (err_flag && $stable(err_code)));
  p_clear_r12: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!err_flag && err_code == 2'b00));
endmodule

// File: rtl/jtag_cfg_bridge.sv
module jtag_cfg_bridge
  import jcb_pkg::*;
#(
  parameter int AW = 22,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tlr,
  input  logic          st_capture,
  input  logic          st_shift,
  input  logic          st_exit1,
  input  logic          st_pause,
  input  logic          st_exit2,
  input  logic          st_update,
  input  logic          tdi,
  input  logic          err_clr,
  output logic          tdo,
  output logic          tdo_oe,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_wr,
  output logic          bus_rd,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ready,
  output logic          err_flag,
  output logic [1:0]    err_code
);
  localparam int ACW = (AW > 1) ? $clog2(AW) : 1;

  jcb_phase_e    phase;
  logic          cmd_rd;
  logic [ACW-1:0] acnt;
  logic [AW-1:0] addr_sh;
  logic [AW-1:0] addr_next;
  logic          addr_last;
  logic          wr_start, wr_bit, wr_partial;
  logic          rd_req, rd_load, rd_shift, rd_cancel, rd_bit, rd_timeout;
  logic [AW-1:0] waddr, raddr;

  generate
    if (AW == 1) begin : g_addr_one
      assign addr_next = tdi;
    end else begin : g_addr_many
      assign addr_next = {tdi, addr_sh[AW-1:1]};
    end
  endgenerate

  assign addr_last = st_shift && (phase == PH_ADDR) && (acnt == ACW'(AW - 1));
  assign wr_start  = addr_last && !cmd_rd;
  assign rd_req    = addr_last && cmd_rd;
  assign wr_bit    = st_shift && (phase == PH_WDATA);
  assign rd_load   = st_exit2 && (phase == PH_RWAIT);
  assign rd_shift  = st_shift && (phase == PH_RDATA);
  assign rd_cancel = st_capture || tlr;

  always_ff @(posedge clk) begin
    if (rst || tlr) begin
      phase   <= PH_IDLE;
      cmd_rd  <= 1'b0;
      acnt    <= '0;
      addr_sh <= '0;
    end else if (st_capture) begin
      phase <= PH_CMD;
    end else if (st_update) begin
      phase <= PH_IDLE;
    end else if (st_shift) begin
      case (phase)
        PH_CMD: begin
          cmd_rd <= tdi;
          acnt   <= '0;
          phase  <= PH_ADDR;
        end
        PH_ADDR: begin
          addr_sh <= addr_next;
          if (acnt == ACW'(AW - 1)) begin
            phase <= cmd_rd ? PH_RWAIT : PH_WDATA;
          end else begin
            acnt <= acnt + 1'b1;
          end
        end
        default: ;
      endcase
    end else if (rd_load) begin
      phase <= PH_RDATA;
    end
  end

  jcb_wr_path #(.AW(AW), .DW(DW)) u_wr (
    .clk(clk), .rst(rst), .start(wr_start), .base(addr_next),
    .bit_en(wr_bit), .tdi(tdi), .bus_wr(bus_wr), .bus_waddr(waddr),
    .bus_wdata(bus_wdata), .partial(wr_partial)
  );

  jcb_rd_path #(.AW(AW), .DW(DW)) u_rd (
    .clk(clk), .rst(rst), .cancel(rd_cancel), .req(rd_req),
    .addr_in(addr_next), .load(rd_load), .shift_en(rd_shift),
    .bus_ready(bus_ready), .bus_rdata(bus_rdata), .bus_rd(bus_rd),
    .bus_raddr(raddr), .tdo_bit(rd_bit), .timeout(rd_timeout)
  );

  jcb_err_sticky u_err (
    .clk(clk), .rst(rst), .clr(err_clr || tlr),
    .ev_partial(st_update && (phase == PH_WDATA) && wr_partial),
    .ev_abort(st_update && (phase == PH_ADDR)),
    .ev_timeout(rd_timeout),
    .err_flag(err_flag), .err_code(err_code)
  );

  assign bus_addr = bus_wr ? waddr : raddr;
  assign tdo      = (phase == PH_RDATA) && rd_bit;
  assign tdo_oe   = st_shift;

  p_write_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_WDATA || (phase == PH_CMD && !cmd_rd)) |-> !tdo);
  p_oe_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (st_exit1 || st_pause || st_exit2) |-> !tdo_oe);
  p_one_state_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({st_capture, st_shift, st_exit1, st_pause, st_exit2, st_update}));
  p_bus_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_rd));
  p_abort_code_r10: assert property (@(posedge clk) disable iff (rst)
    (st_update && phase == PH_ADDR && !err_flag && !err_clr && !tlr)
      |=> (err_code == 2'b10));
  p_partial_code_r9: assert property (@(posedge clk) disable iff (rst)
    (st_update && phase == PH_WDATA && wr_partial && !err_flag && !err_clr && !tlr)
      |=> (err_code == 2'b01));
endmodule

// File: tb/tb_jtag_cfg_bridge.sv
module tb_jtag_cfg_bridge;
  localparam int TAW = 6;
  localparam int TDW = 32;
  localparam int NW  = 1 << TAW;
  localparam int S_IDLE = 0, S_CAP = 1, S_SHIFT = 2, S_EX1 = 3,
                 S_PAUSE = 4, S_EX2 = 5, S_UPD = 6, S_TLR = 7;

  logic clk = 1'b0;
  logic rst, tlr, st_capture, st_shift, st_exit1, st_pause, st_exit2, st_update;
  logic tdi, err_clr, tdo, tdo_oe, bus_wr, bus_rd, bus_ready, err_flag;
  logic [TAW-1:0] bus_addr;
  logic [TDW-1:0] bus_wdata, bus_rdata;
  logic [1:0] err_code;

  int n_chk = 0, n_fail = 0;
  logic s_tdo, s_oe;
  int lat = 2;
  int rcnt = 0;
  logic [TAW-1:0] ra;
  logic [31:0] mem [NW];
  logic [31:0] expm [NW];
  int wcnt = 0, rdcnt = 0;
  logic [TAW-1:0] lw_a, lr_a;
  logic [31:0] lw_d;

  always #2.5 clk = ~clk;

  jtag_cfg_bridge #(.AW(TAW), .DW(TDW)) dut (
    .clk(clk), .rst(rst), .tlr(tlr), .st_capture(st_capture), .st_shift(st_shift),
    .st_exit1(st_exit1), .st_pause(st_pause), .st_exit2(st_exit2),
    .st_update(st_update), .tdi(tdi), .err_clr(err_clr), .tdo(tdo),
    .tdo_oe(tdo_oe), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .err_flag(err_flag), .err_code(err_code)
  );

  function automatic logic [31:0] initv(int i);
    return (i * 32'h0100_0193) ^ 32'h5A5A_0000;
  endfunction

  function automatic logic [31:0] datav(int i);
    return (i * 32'h9E37_79B9) ^ 32'h0F1E_2D3C;
  endfunction

  initial begin
    for (int i = 0; i < NW; i++) begin
      mem[i]  = initv(i);
      expm[i] = initv(i);
    end
  end

  assign bus_ready = (rcnt == 1);
  assign bus_rdata = bus_ready ? mem[ra] : 32'hDEAD_BEEF;

  always @(posedge clk) begin
    if (rst) rcnt <= 0;
    else if (bus_rd) begin
      rcnt  <= lat;
      ra    <= bus_addr;
      lr_a  <= bus_addr;
      rdcnt <= rdcnt + 1;
    end else if (rcnt != 0) rcnt <= rcnt - 1;
    if (!rst && bus_wr) begin
      mem[bus_addr] <= bus_wdata;
      lw_a <= bus_addr;
      lw_d <= bus_wdata;
      wcnt <= wcnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int st, input logic d);
    @(negedge clk);
    st_capture = (st == S_CAP);
    st_shift   = (st == S_SHIFT);
    st_exit1   = (st == S_EX1);
    st_pause   = (st == S_PAUSE);
    st_exit2   = (st == S_EX2);
    st_update  = (st == S_UPD);
    tlr        = (st == S_TLR);
    tdi        = d;
    #1;
    s_tdo = tdo;
    s_oe  = tdo_oe;
  endtask

  task automatic write_scan(input logic [TAW-1:0] a, input logic [63:0] d, input int nbits);
    bit zok = 1'b1, ook = 1'b1;
    tick(S_CAP, 1'b0);
    tick(S_SHIFT, 1'b0);
    if (s_tdo !== 1'b0) zok = 1'b0;
    for (int i = 0; i < TAW; i++) tick(S_SHIFT, a[i]);
    for (int i = 0; i < nbits; i++) begin
      tick(S_SHIFT, d[i]);
      if (s_tdo !== 1'b0) zok = 1'b0;
      if (s_oe !== 1'b1) ook = 1'b0;
    end
    tick(S_EX1, 1'b0);
    chk(s_oe == 1'b0, "R6", "oe in Exit1", 32'(s_oe), 0);
    tick(S_UPD, 1'b0);
    tick(S_IDLE, 1'b0);
    chk(zok, "R5", "tdo zero in write", 32'(zok), 1);
    chk(ook, "R6", "oe in Shift", 32'(ook), 1);
  endtask

  task automatic read_scan(input logic [TAW-1:0] a, input int p, input logic fill,
                           output logic [31:0] got);
    tick(S_CAP, 1'b0);
    tick(S_SHIFT, 1'b1);
    for (int i = 0; i < TAW; i++) tick(S_SHIFT, a[i]);
    tick(S_EX1, fill);
    for (int i = 0; i < p; i++) tick(S_PAUSE, fill);
    chk(s_oe == 1'b0, "R6", "oe in Pause", 32'(s_oe), 0);
    tick(S_EX2, fill);
    for (int i = 0; i < TDW; i++) begin
      tick(S_SHIFT, fill);
      got[i] = s_tdo;
    end
    tick(S_EX1, 1'b0);
    tick(S_UPD, 1'b0);
    tick(S_IDLE, 1'b0);
  endtask

  task automatic abort_scan();
    tick(S_CAP, 1'b0);
    tick(S_SHIFT, 1'b0);
    for (int i = 0; i < 3; i++) tick(S_SHIFT, 1'b1);
    tick(S_EX1, 1'b0);
    tick(S_UPD, 1'b0);
    tick(S_IDLE, 1'b0);
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    err_clr = 1'b1;
    tick(S_IDLE, 1'b0);
    err_clr = 1'b0;
    tick(S_IDLE, 1'b0);
  endtask

  task automatic finish_run();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] got;
    int w0, r0;
    rst = 1'b1; tlr = 0; st_capture = 0; st_shift = 0; st_exit1 = 0;
    st_pause = 0; st_exit2 = 0; st_update = 0; tdi = 0; err_clr = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    tick(S_IDLE, 1'b0);
    chk(tdo_oe == 0 && bus_wr == 0 && bus_rd == 0, "R6", "reset outputs",
        {29'b0, tdo_oe, bus_wr, bus_rd}, 0);
    chk(err_flag == 0 && err_code == 0, "R12", "reset error", 32'(err_code), 0);

    // R1 R2 R3: write every address once
    for (int a = 0; a < NW; a++) begin
      w0 = wcnt;
      write_scan(TAW'(a), {32'b0, datav(a)}, 32);
      expm[a] = datav(a);
      chk(wcnt == w0 + 1, "R3", "one write per word", 32'(wcnt - w0), 1);
      chk(lw_a == TAW'(a), "R2", "write address", 32'(lw_a), 32'(a));
      chk(lw_d == datav(a), "R3", "write data", lw_d, datav(a));
    end

    // R1 R7 R8: read every address, ready before or during Exit2
    for (int a = 0; a < NW; a++) begin
      lat = 1 + (a % 3);
      w0 = wcnt; r0 = rdcnt;
      read_scan(TAW'(a), 2, a[0], got);
      chk(got == expm[a], "R8", "read data", got, expm[a]);
      chk(rdcnt == r0 + 1 && lr_a == TAW'(a), "R7", "read request address", 32'(lr_a), 32'(a));
      chk(wcnt == w0, "R1", "read makes no write", 32'(wcnt - w0), 0);
    end
    chk(err_flag == 0, "R12", "no error after clean scans", 32'(err_code), 0);

    // R4: two words from the top address wrap to zero
    w0 = wcnt;
    write_scan(TAW'(NW - 1), {32'hCAFE_0001, 32'h1234_ABCD}, 64);
    expm[NW-1] = 32'h1234_ABCD;
    expm[0] = 32'hCAFE_0001;
    chk(wcnt == w0 + 2, "R4", "two writes", 32'(wcnt - w0), 2);
    chk(lw_a == 0 && lw_d == 32'hCAFE_0001, "R4", "second word wraps", 32'(lw_a), 0);
    lat = 2;
    read_scan(TAW'(NW - 1), 3, 1'b0, got);
    chk(got == expm[NW-1], "R4", "first word readback", got, expm[NW-1]);
    read_scan('0, 3, 1'b0, got);
    chk(got == expm[0], "R4", "second word readback", got, expm[0]);

    // R7: TDI ones during read data shifting are ignored
    w0 = wcnt;
    read_scan(TAW'(5), 3, 1'b1, got);
    chk(wcnt == w0 && got == expm[5], "R7", "tdi ignored in read", got, expm[5]);

    // R9: 40 bits -> one full word, 8-bit remainder dropped
    w0 = wcnt;
    write_scan(TAW'(10), {24'b0, 8'hFF, 32'h0BAD_F00D}, 40);
    expm[10] = 32'h0BAD_F00D;
    chk(wcnt == w0 + 1, "R9", "only full word written", 32'(wcnt - w0), 1);
    chk(err_flag == 1 && err_code == 2'b01, "R9", "partial code", 32'(err_code), 1);
    read_scan(TAW'(11), 3, 1'b0, got);
    chk(got == expm[11], "R9", "next word untouched", got, expm[11]);

    // R12: first code held through a later abort
    abort_scan();
    chk(err_code == 2'b01, "R12", "first code sticks", 32'(err_code), 1);
    pulse_clr();
    chk(err_flag == 0 && err_code == 0, "R12", "cleared by err_clr", 32'(err_code), 0);

    // R10: update during address
    w0 = wcnt;
    abort_scan();
    chk(err_flag == 1 && err_code == 2'b10, "R10", "abort code", 32'(err_code), 2);
    chk(wcnt == w0, "R10", "no write on abort", 32'(wcnt - w0), 0);
    tick(S_TLR, 1'b0);
    tick(S_IDLE, 1'b0);
    chk(err_flag == 0 && err_code == 0, "R12", "cleared by tlr", 32'(err_code), 0);

    // R11: ready one cycle after Exit2
    lat = 4;
    read_scan(TAW'(7), 2, 1'b0, got);
    chk(got == 0, "R11", "timeout shifts zeros", got, 0);
    chk(err_flag == 1 && err_code == 2'b11, "R11", "timeout code", 32'(err_code), 3);
    repeat (8) tick(S_IDLE, 1'b0);
    chk(err_code == 2'b11, "R12", "late ready keeps code", 32'(err_code), 3);
    pulse_clr();
    lat = 1;
    read_scan(TAW'(7), 2, 1'b0, got);
    chk(got == expm[7] && err_flag == 0, "R8", "read after timeout", got, expm[7]);

    finish_run();
  end
endmodule